// File: doc/BRIEF.md
# T1 Framing Bit Error Qualifier

This block sits behind a T1 framer that has already located the superframe. Each received framing bit arrives with a valid strobe, its frame number within the superframe, and the framer's in-frame flag. The block decides whether that bit position is one that counts for the selected superframe format. If it does, the block compares the received bit with the value that format expects there. When a counted bit is wrong, the block raises a single-cycle error strobe that an error counter downstream can accumulate.

Three formats are supported:

- **ESF:** the framing pattern bits sit in every fourth frame of a 24-frame superframe.
- **D4:** the terminal framing bits sit in the odd frames. The signalling framing bits sit in the even frames and are checked only when software enables it. The frame-12 position is always exempt.
- **SLC-96:** only the odd-frame terminal bits are judged.

No strobe is produced while the framer reports loss of frame.

Top module: `t1_fbit_qualifier`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `errStrobe` is low.
- R2: `errStrobe` is high in cycle N+1 only if `fbitValid` was high in cycle N; each valid framing bit produces at most one strobe cycle, exactly one cycle after it is presented.
- R3: When `inFrame` is low in the cycle a framing bit is presented, that bit produces no strobe.
- R4: With `fmtSel` = 2'b01 (ESF), frames 4, 8, 12, 16, 20 and 24 expect the bits 0, 0, 1, 0, 1, 1 respectively. A mismatch on any of them strobes.
- R5: In ESF, frames whose number is not a multiple of four never strobe.
- R6: With `fmtSel` = 2'b00 (D4), odd frames 1, 3, 5, 7, 9 and 11 expect 1, 0, 1, 0, 1, 0. A mismatch always strobes, whatever `fsCountEn` is.
- R7: In D4, even frames 2, 4, 6, 8 and 10 expect 0, 0, 1, 1, 1. A mismatch strobes only when `fsCountEn` is high.
- R8: In D4, frame 12 never strobes, whatever the received bit or `fsCountEn`.
- R9: With `fmtSel` = 2'b10 (SLC-96), odd frames 1 to 11 are checked against the same pattern as R6. Even frames never strobe, whatever `fsCountEn` is.
- R10: `fmtSel` = 2'b11, a frame number of 0, or a frame number beyond the superframe length (24 for ESF, 12 for D4 and SLC-96) never strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fbitValid | input | 1 | A framing bit is presented this cycle |
| fbitVal | input | 1 | Received framing bit value |
| frameIdx | input | IDX_W (5) | Frame number within the superframe, counting from 1 |
| fmtSel | input | 2 | Superframe format: 00 D4, 01 ESF, 10 SLC-96, 11 unused |
| fsCountEn | input | 1 | Enables counting of D4 signalling framing bit errors |
| inFrame | input | 1 | Framer is in frame |
| errStrobe | output | 1 | One-cycle framing bit error pulse |

## Verification
Every format is swept over every frame number from 0 to 31, with both received bit values. Each sweep runs with the enable on and off and with the in-frame flag high and low.

- **Matching and inverted bits:** these separate an error that is recognised from a position that is merely checked.
- **Enable on versus off:** shows that only D4 even frames depend on it, and that frame 12 and SLC-96 even frames never do.
- **Out-of-range frame numbers and the unused format code:** confirm that these stay silent.

A random phase then mixes idle cycles, back-to-back valid bits and loss of frame, to test the one-cycle timing of the strobe.

// File: rtl/t1fq_pkg.sv
`timescale 1ns/1ps
package t1fq_pkg;

  typedef enum logic [1:0] {
    FMT_D4   = 2'b00,
    FMT_ESF  = 2'b01,
    FMT_SLC  = 2'b10,
    FMT_NONE = 2'b11
  } fmt_e;

  // Strobes from the position decoder to the compare datapath
  typedef struct packed {
    logic check;   // this framing bit counts toward errors
    logic expBit;  // value the pattern expects here
  } chkCtrl_s;

  localparam int PAT_LEN  = 6;  // pattern bits per superframe for each bit class
  localparam int ESF_STEP = 4;  // ESF pattern bit spacing in frames
  localparam int FT_STEP  = 2;  // D4 / SLC-96 terminal and signalling spacing

  // bit k = expected value of the k-th occurrence
  localparam logic [PAT_LEN-1:0] ESF_PAT = 6'b110100; // frames 4..24 : 0 0 1 0 1 1
  localparam logic [PAT_LEN-1:0] FT_PAT  = 6'b010101; // frames 1..11 : 1 0 1 0 1 0
  localparam logic [PAT_LEN-1:0] FS_PAT  = 6'b011100; // frames 2..12 : 0 0 1 1 1 0

endpackage

// File: rtl/t1fq_ctrl.sv
`timescale 1ns/1ps
module t1fq_ctrl
  import t1fq_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             fbitValid,
  input  logic [IDX_W-1:0] frameIdx,
  input  logic [1:0]       fmtSel,
  input  logic             fsCountEn,
  input  logic             inFrame,
  output chkCtrl_s         ctrl
);

  localparam int ESF_LEN = ESF_STEP * PAT_LEN;
  localparam int D4_LEN  = FT_STEP * PAT_LEN;
  localparam logic [IDX_W-1:0] EXEMPT_IDX = IDX_W'(D4_LEN);

  fmt_e fmt;
  assign fmt = fmt_e'(fmtSel);

  logic     esfHit, esfExp;
  logic     ftHit,  ftExp;
  logic     fsHit,  fsExp;

  // Position matching: one comparator per pattern occurrence
  always_comb begin
    esfHit = 1'b0; esfExp = 1'b0;
    ftHit  = 1'b0; ftExp  = 1'b0;
    fsHit  = 1'b0; fsExp  = 1'b0;
    for (int k = 0; k < PAT_LEN; k++) begin
      if (frameIdx == IDX_W'((k + 1) * ESF_STEP)) begin
        esfHit = 1'b1;
        esfExp = ESF_PAT[k];
      end
      if (frameIdx == IDX_W'(k * FT_STEP + 1)) begin
        ftHit = 1'b1;
        ftExp = FT_PAT[k];
      end
      if (frameIdx == IDX_W'((k + 1) * FT_STEP)) begin
        fsHit = 1'b1;
        fsExp = FS_PAT[k];
      end
    end
  end

  // Format qualification
  always_comb begin
    ctrl = '0;
    if (fbitValid && inFrame) begin
      unique case (fmt)
        FMT_ESF: begin
          ctrl.check  = esfHit;
          ctrl.expBit = esfExp;
        end
        FMT_D4: begin
          if (ftHit) begin
            ctrl.check  = 1'b1;
            ctrl.expBit = ftExp;
          end else if (fsHit && fsCountEn && (frameIdx != EXEMPT_IDX)) begin
            ctrl.check  = 1'b1;
            ctrl.expBit = fsExp;
          end
        end
        FMT_SLC: begin
          ctrl.check  = ftHit;
          ctrl.expBit = ftExp;
        end
        default: ctrl = '0;
      endcase
    end
  end

endmodule

// File: rtl/t1fq_datapath.sv
`timescale 1ns/1ps
module t1fq_datapath
  import t1fq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     fbitVal,
  input  chkCtrl_s ctrl,
  output logic     errStrobe
);

  logic mismatch;
  assign mismatch = ctrl.check && (fbitVal != ctrl.expBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errStrobe <= 1'b0;
    else       errStrobe <= mismatch;
  end

endmodule

// File: rtl/t1_fbit_qualifier.sv
`timescale 1ns/1ps
module t1_fbit_qualifier
  import t1fq_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fbitValid,
  input  logic             fbitVal,
  input  logic [IDX_W-1:0] frameIdx,
  input  logic [1:0]       fmtSel,
  input  logic             fsCountEn,
  input  logic             inFrame,
  output logic             errStrobe
);

  chkCtrl_s ctrl;

  t1fq_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .fbitValid (fbitValid),
    .frameIdx  (frameIdx),
    .fmtSel    (fmtSel),
    .fsCountEn (fsCountEn),
    .inFrame   (inFrame),
    .ctrl      (ctrl)
  );

  t1fq_datapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .fbitVal   (fbitVal),
    .ctrl      (ctrl),
    .errStrobe (errStrobe)
  );

endmodule

// File: rtl/t1fq_checker.sv
`timescale 1ns/1ps
module t1fq_checker #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             fbitValid,
  input logic             fbitVal,
  input logic [IDX_W-1:0] frameIdx,
  input logic [1:0]       fmtSel,
  input logic             fsCountEn,
  input logic             inFrame,
  input logic             errStrobe
);

  AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    errStrobe |-> $past(fbitValid));                                         // R2

  AST_SILENT_OUT_OF_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    errStrobe |-> $past(inFrame));                                           // R3

  AST_ESF_MULT4_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (errStrobe && $past(fmtSel) == 2'b01) |-> ($past(frameIdx[1:0]) == 2'b00)); // R5

  AST_D4_FS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (errStrobe && $past(fmtSel) == 2'b00 && !$past(frameIdx[0])) |-> $past(fsCountEn)); // R7

  AST_FRAME12_EXEMPT: assert property (@(posedge clk) disable iff (!rstN)
    errStrobe |-> !($past(fmtSel) == 2'b00 && $past(frameIdx) == IDX_W'(12))); // R8

  AST_SLC_ODD_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (errStrobe && $past(fmtSel) == 2'b10) |-> $past(frameIdx[0]));           // R9

  AST_UNUSED_FMT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    errStrobe |-> ($past(fmtSel) != 2'b11 && $past(frameIdx) != '0));       // R10

endmodule

bind t1_fbit_qualifier t1fq_checker #(.IDX_W(IDX_W)) uChk (.*);

// File: tb/t1_fbit_qualifier_test.sv
`timescale 1ns/1ps
module t1_fbit_qualifier_test;

  localparam int IDX_W = 5;

  logic             clk = 1'b0;
  logic             rstN;
  logic             fbitValid, fbitVal, fsCountEn, inFrame;
  logic [IDX_W-1:0] frameIdx;
  logic [1:0]       fmtSel;
  logic             errStrobe;

  int    vecCount  = 0;
  int    failCount = 0;
  bit    expNext   = 1'b0;
  string tagNext   = "R1";
  bit    finished  = 1'b0;

  int esfPat[6] = '{0, 0, 1, 0, 1, 1};
  int ftPat[6]  = '{1, 0, 1, 0, 1, 0};
  int fsPat[6]  = '{0, 0, 1, 1, 1, 0};

  always #5 clk = ~clk;

  t1_fbit_qualifier #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rstN(rstN), .fbitValid(fbitValid), .fbitVal(fbitVal),
    .frameIdx(frameIdx), .fmtSel(fmtSel), .fsCountEn(fsCountEn),
    .inFrame(inFrame), .errStrobe(errStrobe)
  );

  // Behavioural reference: expected strobe for one presented bit
  function automatic bit refErr(int fmt, bit en, bit inF, bit v, int idx, bit fb,
                                output string tag);
    int expV;
    bit counted;
    counted = 1'b0;
    expV    = 0;
    tag     = "R2";
    if (!v) begin
      tag = "R2";
    end else if (!inF) begin
      tag = "R3";
    end else if (fmt == 3 || idx == 0) begin
      tag = "R10";
    end else if (fmt == 1) begin
      if (idx > 24)            tag = "R10";
      else if (idx % 4 != 0)   tag = "R5";
      else begin
        tag = "R4"; counted = 1'b1; expV = esfPat[idx/4 - 1];
      end
    end else begin
      if (idx > 12) tag = "R10";
      else if (idx % 2 == 1) begin
        tag = (fmt == 0) ? "R6" : "R9";
        counted = 1'b1; expV = ftPat[(idx-1)/2];
      end else if (fmt == 2) tag = "R9";
      else if (idx == 12)    tag = "R8";
      else begin
        tag = "R7";
        if (en) begin counted = 1'b1; expV = fsPat[idx/2 - 1]; end
      end
    end
    return counted && (int'(fb) != expV);
  endfunction

  task automatic checkOut(bit expV, string tag);
    vecCount++;
    if (errStrobe !== expV) begin
      failCount++;
      $display("FAIL %s: errStrobe=%0b expected=%0b (fmt=%0d idx=%0d)",
               tag, errStrobe, expV, fmtSel, frameIdx);
    end
  endtask

  // One clock: compare the previous vector's result, then present a new one
  task automatic applyVec(int fmt, bit en, bit inF, bit v, int idx, bit fb);
    string t;
    @(negedge clk);
    checkOut(expNext, tagNext);
    fmtSel    = 2'(fmt);
    fsCountEn = en;
    inFrame   = inF;
    fbitValid = v;
    frameIdx  = IDX_W'(idx);
    fbitVal   = fb;
    expNext   = refErr(fmt, en, inF, v, idx, fb, t);
    tagNext   = t;
  endtask

  initial begin
    rstN = 1'b0; fbitValid = 1'b1; fbitVal = 1'b0; frameIdx = IDX_W'(1);
    fmtSel = 2'b00; fsCountEn = 1'b1; inFrame = 1'b1;  // mismatching bit held in reset
    repeat (3) begin
      @(negedge clk);
      checkOut(1'b0, "R1");
    end
    rstN = 1'b1;
    fbitValid = 1'b0;
    expNext = 1'b0; tagNext = "R1";

    // Exhaustive sweep over format, enable, in-frame, frame number and bit value
    for (int f = 0; f < 4; f++)
      for (int e = 0; e < 2; e++)
        for (int i = 0; i < 2; i++)
          for (int x = 0; x < 32; x++)
            for (int b = 0; b < 2; b++)
              applyVec(f, bit'(e), bit'(i), 1'b1, x, bit'(b));

    // Random mix: idle cycles, back-to-back bits, loss of frame
    for (int n = 0; n < 3000; n++)
      applyVec($urandom_range(0, 3), bit'($urandom_range(0, 1)),
               ($urandom_range(0, 7) != 0), bit'($urandom_range(0, 1)),
               $urandom_range(0, 26), bit'($urandom_range(0, 1)));

    applyVec(0, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    @(negedge clk);
    checkOut(expNext, tagNext);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

endmodule